// File: doc/BRIEF.md
# Bit Scan and Bit Test Unit

This block is a combinational slice of an integer execution unit. It covers the bit-oriented operations on an operand that is either a half-width word (16 bits) or a full-width word (32 bits). It does two kinds of work. A priority scan finds the lowest or the highest set bit. A single-bit test reads one bit and can also flip, set or clear that bit in place.

Each cycle the issuing pipeline stage presents an operation code, a width select, the operand, a bit offset and the current destination value. In the same cycle the unit returns a result word, a carry flag and a zero flag. A scan of an all-zero operand leaves the destination value as it was and reports the empty source through the zero flag. A bit test writes the addressed bit's old value to the carry flag. The unit holds no state.

Top module: `bitop_unit`

## Requirements
- R1: Operation codes are 3 bits: 0 forward scan, 1 reverse scan, 2 test, 3 test-and-complement, 4 test-and-set, 5 test-and-clear. Codes 6 and 7 return the width-masked operand with carry 0 and zero 0.
- R2: Forward scan of a non-zero operand returns the index of the lowest set bit, counting bit 0 as the least significant bit. The index is zero-extended to the result width. Zero flag and carry are 0.
- R3: Reverse scan of a non-zero operand returns the index of the highest set bit within the selected width, zero-extended. Zero flag and carry are 0.
- R4: A scan of an operand that is zero within the selected width sets the zero flag, clears the carry and returns the destination input unchanged.
- R5: For codes 2 to 5 the bit position is the offset modulo the width. In narrow mode (`wide_i`=0) this is offset bits [3:0]. In wide mode (`wide_i`=1) it is offset bits [4:0]. All higher offset bits are ignored.
- R6: Test (code 2) copies the addressed bit to carry and returns the masked operand unchanged. The zero flag is 0.
- R7: Test-and-complement returns the masked operand with the addressed bit inverted. Carry is the bit's old value.
- R8: Test-and-set returns the masked operand with the addressed bit at 1. Carry is the old value.
- R9: Test-and-clear returns the masked operand with the addressed bit at 0. Carry is the old value.
- R10: In narrow mode, operand bits 31..16 are ignored. Every result except the zero-scan passthrough has bits 31..16 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (R1) |
| wide_i | input | 1 | 1 selects 32-bit width, 0 selects 16-bit width |
| opnd_i | input | 32 | Source operand |
| offset_i | input | 8 | Bit offset for the test operations |
| dest_i | input | 32 | Current destination value, returned on a zero-source scan |
| result_o | output | 32 | Result word |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |

## Verification
The bench uses the default build: a 32-bit data path and an 8-bit offset. With an 8-bit offset, values of 16 through 255 can be driven, so the modulo truncation can be checked in both widths, including offsets far beyond the operand size. Because the full width is 32, narrow mode leaves 16 upper operand bits that must be ignored. Garbage placed in those bits shows whether a scan or bit operation ever reaches past bit 15.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [2:0] {
        OP_SCAN_LO  = 3'd0,
        OP_SCAN_HI  = 3'd1,
        OP_TEST     = 3'd2,
        OP_TEST_FLIP = 3'd3,
        OP_TEST_SET = 3'd4,
        OP_TEST_CLR = 3'd5
    } bitop_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_FLIP = 2'd1,
        ACT_SET  = 2'd2,
        ACT_CLR  = 2'd3
    } bit_act_e;

    typedef struct packed {
        logic carry;
        logic zero;
    } bitop_flags_t;

    function automatic bit_act_e act_of(input logic [2:0] op);
        case (op)
            OP_TEST_FLIP: return ACT_FLIP;
            OP_TEST_SET:  return ACT_SET;
            OP_TEST_CLR:  return ACT_CLR;
            default:      return ACT_KEEP;
        endcase
    endfunction

    function automatic logic is_bit_op(input logic [2:0] op);
        return (op >= OP_TEST) && (op <= OP_TEST_CLR);
    endfunction

endpackage

// File: rtl/bitop_scan.sv
module bitop_scan #(
    parameter int DATA_W  = 32,
    parameter bit FROM_HI = 1'b0,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] vec_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);

    assign hit_o = |vec_i;

    generate
        if (FROM_HI) begin : g_hi
            // Ascending walk: the last set bit seen is the highest one.
            always_comb begin
                idx_o = '0;
                for (int i = 0; i < DATA_W; i++) begin
                    if (vec_i[i]) idx_o = IDX_W'(i);
                end
            end
        end else begin : g_lo
            // Descending walk: the last set bit seen is the lowest one.
            always_comb begin
                idx_o = '0;
                for (int i = DATA_W - 1; i >= 0; i--) begin
                    if (vec_i[i]) idx_o = IDX_W'(i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bitop_modify.sv
module bitop_modify
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] vec_i,
    input  logic [IDX_W-1:0]  pos_i,
    input  bit_act_e          act_i,
    output logic              old_bit_o,
    output logic [DATA_W-1:0] vec_o
);

    logic [DATA_W-1:0] sel;

    assign sel       = {{(DATA_W-1){1'b0}}, 1'b1} << pos_i;
    assign old_bit_o = |(vec_i & sel);

    always_comb begin
        case (act_i)
            ACT_FLIP: vec_o = vec_i ^ sel;
            ACT_SET:  vec_o = vec_i | sel;
            ACT_CLR:  vec_o = vec_i & ~sel;
            default:  vec_o = vec_i;
        endcase
    end

    always_comb begin
        // R7
        single_bit_touch_chk: assert ($countones(vec_o ^ vec_i) <= 1)
            else $error("modify touched more than one bit");
        // R8
        set_forces_one_chk: assert (!(act_i == ACT_SET) || (vec_o[pos_i] == 1'b1))
            else $error("set did not force bit");
        // R9
        clr_forces_zero_chk: assert (!(act_i == ACT_CLR) || (vec_o[pos_i] == 1'b0))
            else $error("clear did not force bit");
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 8,
    localparam int IDX_W    = $clog2(DATA_W),
    localparam int NARROW_W = DATA_W / 2
) (
    input  logic [2:0]        op_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic [DATA_W-1:0] dest_i,
    output logic [DATA_W-1:0] result_o,
    output logic              cf_o,
    output logic              zf_o
);

    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] opnd_m;
    logic [IDX_W-1:0]  bit_pos;
    logic              lo_hit, hi_hit;
    logic [IDX_W-1:0]  lo_idx, hi_idx;
    logic              old_bit;
    logic [DATA_W-1:0] mod_vec;
    bitop_flags_t      flags;

    assign width_mask = wide_i ? {DATA_W{1'b1}} : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    assign opnd_m     = opnd_i & width_mask;
    // Offset modulo the selected width.
    assign bit_pos    = wide_i ? offset_i[IDX_W-1:0] : {1'b0, offset_i[IDX_W-2:0]};

    bitop_scan #(.DATA_W(DATA_W), .FROM_HI(1'b0)) u_scan_lo (
        .vec_i (opnd_m),
        .hit_o (lo_hit),
        .idx_o (lo_idx)
    );

    bitop_scan #(.DATA_W(DATA_W), .FROM_HI(1'b1)) u_scan_hi (
        .vec_i (opnd_m),
        .hit_o (hi_hit),
        .idx_o (hi_idx)
    );

    bitop_modify #(.DATA_W(DATA_W)) u_modify (
        .vec_i     (opnd_m),
        .pos_i     (bit_pos),
        .act_i     (act_of(op_i)),
        .old_bit_o (old_bit),
        .vec_o     (mod_vec)
    );

    always_comb begin
        flags    = '{carry: 1'b0, zero: 1'b0};
        result_o = opnd_m;
        case (op_i)
            OP_SCAN_LO: begin
                if (lo_hit) result_o = {{(DATA_W-IDX_W){1'b0}}, lo_idx};
                else begin
                    result_o   = dest_i;
                    flags.zero = 1'b1;
                end
            end
            OP_SCAN_HI: begin
                if (hi_hit) result_o = {{(DATA_W-IDX_W){1'b0}}, hi_idx};
                else begin
                    result_o   = dest_i;
                    flags.zero = 1'b1;
                end
            end
            default: begin
                if (is_bit_op(op_i)) begin
                    result_o    = mod_vec;
                    flags.carry = old_bit;
                end
            end
        endcase
    end

    assign cf_o = flags.carry;
    assign zf_o = flags.zero;

    always_comb begin
        // R2
        lo_scan_lowest_chk: assert (!lo_hit ||
                ((opnd_m[lo_idx] == 1'b1) &&
                 ((opnd_m & ((DATA_W'(1) << lo_idx) - DATA_W'(1))) == '0)))
            else $error("forward scan index wrong");
        // R3
        hi_scan_highest_chk: assert (!hi_hit || ((opnd_m >> hi_idx) == DATA_W'(1)))
            else $error("reverse scan index wrong");
        // R4
        zero_scan_keep_chk: assert (!(op_i <= 3'd1 && opnd_m == '0) ||
                (zf_o && !cf_o && result_o == dest_i))
            else $error("zero-source scan mishandled");
        // R10
        narrow_upper_clear_chk: assert (wide_i || zf_o ||
                ((result_o & ~width_mask) == '0))
            else $error("narrow result has upper bits");
        // R6
        test_carry_bit_chk: assert (!is_bit_op(op_i) || (cf_o == opnd_m[bit_pos]))
            else $error("carry is not the addressed bit");
    end

endmodule

// File: tb/bitop_unit_tb_top.sv
module bitop_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    op;
    logic          wide;
    logic [DW-1:0] opnd;
    logic [OW-1:0] offset;
    logic [DW-1:0] dest;
    logic [DW-1:0] result;
    logic          cf, zf;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit #(.DATA_W(DW), .OFS_W(OW)) dut_i (
        .op_i     (op),
        .wide_i   (wide),
        .opnd_i   (opnd),
        .offset_i (offset),
        .dest_i   (dest),
        .result_o (result),
        .cf_o     (cf),
        .zf_o     (zf)
    );

    // Independent reference built from the requirement text.
    task automatic reference(input logic [2:0] o, input logic w, input logic [DW-1:0] a,
                             input logic [OW-1:0] ofs, input logic [DW-1:0] d,
                             output logic [DW-1:0] r, output logic c, output logic z);
        int width = w ? 32 : 16;
        logic [DW-1:0] m = '0;
        int pos = int'(ofs) % width;
        int found = -1;
        for (int i = 0; i < width; i++) m[i] = a[i];
        r = m; c = 1'b0; z = 1'b0;
        case (o)
            3'd0: begin
                for (int i = width - 1; i >= 0; i--) if (m[i]) found = i;
                if (found < 0) begin r = d; z = 1'b1; end else r = DW'(found);
            end
            3'd1: begin
                for (int i = 0; i < width; i++) if (m[i]) found = i;
                if (found < 0) begin r = d; z = 1'b1; end else r = DW'(found);
            end
            3'd2: c = m[pos];
            3'd3: begin c = m[pos]; r[pos] = ~m[pos]; end
            3'd4: begin c = m[pos]; r[pos] = 1'b1; end
            3'd5: begin c = m[pos]; r[pos] = 1'b0; end
            default: ;
        endcase
    endtask

    task automatic apply_check(input string req, input logic [2:0] o, input logic w,
                               input logic [DW-1:0] a, input logic [OW-1:0] ofs,
                               input logic [DW-1:0] d);
        logic [DW-1:0] er;
        logic ec, ez;
        @(negedge clk);
        op = o; wide = w; opnd = a; offset = ofs; dest = d;
        #1;
        reference(o, w, a, ofs, d, er, ec, ez);
        checks++;
        if (result !== er || cf !== ec || ez !== zf) begin
            errors++;
            $display("FAIL %s: op=%0d w=%0b a=%h ofs=%0d actual r=%h cf=%b zf=%b expected r=%h cf=%b zf=%b",
                     req, o, w, a, ofs, result, cf, zf, er, ec, ez);
        end
    endtask

    task automatic expect_vals(input string req, input logic [DW-1:0] er, input logic ec, input logic ez);
        checks++;
        if (result !== er || cf !== ec || zf !== ez) begin
            errors++;
            $display("FAIL %s: actual r=%h cf=%b zf=%b expected r=%h cf=%b zf=%b",
                     req, result, cf, zf, er, ec, ez);
        end
    endtask

    task automatic t_reset_state;
        @(negedge clk); #1;
        // idle inputs are a forward scan of zero: R4
        expect_vals("R4 reset", 32'h0, 1'b0, 1'b1);
    endtask

    task automatic t_forward_scan;
        apply_check("R2", 3'd0, 1'b1, 32'h0000_0001, 8'd0, 32'hdead_beef);
        apply_check("R2", 3'd0, 1'b1, 32'h8000_0000, 8'd0, 32'h0);
        expect_vals("R2 top", 32'd31, 1'b0, 1'b0);
        apply_check("R2", 3'd0, 1'b1, 32'h0F00_F000, 8'd0, 32'h0);
        expect_vals("R2 mid", 32'd12, 1'b0, 1'b0);
        apply_check("R2", 3'd0, 1'b0, 32'h0000_4000, 8'd0, 32'h0);
    endtask

    task automatic t_reverse_scan;
        apply_check("R3", 3'd1, 1'b1, 32'h0000_0001, 8'd0, 32'h0);
        apply_check("R3", 3'd1, 1'b1, 32'h0001_0010, 8'd0, 32'h0);
        expect_vals("R3 mid", 32'd16, 1'b0, 1'b0);
        apply_check("R3", 3'd1, 1'b0, 32'h0000_8001, 8'd0, 32'h0);
        expect_vals("R3 narrow top", 32'd15, 1'b0, 1'b0);
    endtask

    task automatic t_zero_scan;
        apply_check("R4", 3'd0, 1'b1, 32'h0, 8'd0, 32'h1234_5678);
        expect_vals("R4 fwd keep", 32'h1234_5678, 1'b0, 1'b1);
        apply_check("R4", 3'd1, 1'b1, 32'h0, 8'd0, 32'hCAFE_0001);
        expect_vals("R4 rev keep", 32'hCAFE_0001, 1'b0, 1'b1);
        // narrow with only upper garbage counts as zero: R10
        apply_check("R10", 3'd1, 1'b0, 32'hFFFF_0000, 8'd0, 32'hA5A5_A5A5);
        expect_vals("R10 narrow zero", 32'hA5A5_A5A5, 1'b0, 1'b1);
        apply_check("R10", 3'd0, 1'b0, 32'hFFFF_0000, 8'd0, 32'h0000_0007);
    endtask

    task automatic t_modulo;
        apply_check("R5", 3'd2, 1'b0, 32'h0000_0002, 8'd17, 32'h0);
        expect_vals("R5 narrow 17", 32'h0000_0002, 1'b1, 1'b0);
        apply_check("R5", 3'd4, 1'b1, 32'h0, 8'd49, 32'h0);
        expect_vals("R5 wide 49", 32'h0002_0000, 1'b0, 1'b0);
        apply_check("R5", 3'd3, 1'b0, 32'h0, 8'd255, 32'h0);
        expect_vals("R5 narrow 255", 32'h0000_8000, 1'b0, 1'b0);
    endtask

    task automatic t_bit_ops;
        apply_check("R6", 3'd2, 1'b1, 32'h0002_0000, 8'd17, 32'h0);
        expect_vals("R6 test", 32'h0002_0000, 1'b1, 1'b0);
        apply_check("R6", 3'd2, 1'b1, 32'hFFFD_FFFF, 8'd17, 32'h0);
        apply_check("R7", 3'd3, 1'b1, 32'h0000_0020, 8'd5, 32'h0);
        expect_vals("R7 flip", 32'h0, 1'b1, 1'b0);
        apply_check("R7", 3'd3, 1'b1, 32'h0, 8'd31, 32'h0);
        apply_check("R8", 3'd4, 1'b1, 32'h0000_0020, 8'd5, 32'h0);
        expect_vals("R8 set already", 32'h0000_0020, 1'b1, 1'b0);
        apply_check("R8", 3'd4, 1'b0, 32'h0, 8'd0, 32'h0);
        apply_check("R9", 3'd5, 1'b1, 32'hFFFF_FFFF, 8'd0, 32'h0);
        expect_vals("R9 clr", 32'hFFFF_FFFE, 1'b1, 1'b0);
        apply_check("R9", 3'd5, 1'b1, 32'h0, 8'd9, 32'h0);
        apply_check("R10", 3'd3, 1'b0, 32'hABCD_0000, 8'd3, 32'h0);
        expect_vals("R10 narrow bitop", 32'h0000_0008, 1'b0, 1'b0);
    endtask

    task automatic t_reserved;
        apply_check("R1", 3'd6, 1'b1, 32'h1357_9BDF, 8'd3, 32'h0);
        expect_vals("R1 code6", 32'h1357_9BDF, 1'b0, 1'b0);
        apply_check("R1", 3'd7, 1'b0, 32'h1357_9BDF, 8'd3, 32'h0);
        expect_vals("R1 code7", 32'h0000_9BDF, 1'b0, 1'b0);
    endtask

    task automatic t_random;
        for (int k = 0; k < 400; k++) begin
            logic [DW-1:0] a = $urandom;
            if (k % 4 == 0) a = a & (DW'(1) << ($urandom % 32));
            apply_check("R1 mix", 3'($urandom % 8), 1'($urandom % 2), a,
                        8'($urandom), $urandom);
        end
    endtask

    initial begin
        op = 3'd0; wide = 1'b1; opnd = '0; offset = '0; dest = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_forward_scan();
        t_reverse_scan();
        t_zero_scan();
        t_modulo();
        t_bit_ops();
        t_reserved();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule